// File: doc/BRIEF.md
# Decimal Millisecond Stopwatch Counter

This block keeps a three-digit binary-coded-decimal count with one-millisecond resolution. An external 1 kHz tick strobe, one clock cycle wide, advances the count by one. Whether a tick is counted is decided by a run gate. The gate has four modes. In the first, software holds a run bit. In the second, the counter runs while an external pin is high, which measures pulse width. In the third, successive rising edges on that pin start and then stop the counter, which measures period. The fourth mode holds the count still.

When the count crosses a decimal boundary, a one-cycle interrupt strobe is raised. Software picks the boundary: every tenth of a second or every full second. A software clear returns the count to zero. The clear wins over a tick that arrives in the same cycle. The tick generator, bus decoding and pin debouncing are outside the block. The pin input is taken as already synchronised to the clock.

Top module: `msec_bcd_timer`

## Requirements
- R1: After a synchronous active-low reset, `count_bcd` reads 0x000 and `irq` is 0.
- R2: Each 4-bit digit of `count_bcd` (bits 3:0 units, 7:4 tens, 11:8 hundreds) stays within 0 to 9. A digit stepping past 9 returns to 0 and carries one into the next digit.
- R3: An increment from 999 gives 000.
- R4: The count changes only in response to a clock edge where `tick_1k` is 1 and the gate is enabled. Each such edge adds exactly one, and the new value is visible after that edge.
- R5: With `mode_sel` = 0 (software mode), the gate is enabled exactly while `sw_run` is 1.
- R6: With `mode_sel` = 1 (pulse-width mode), the gate is enabled exactly while `ext_in` is 1.
- R7: With `mode_sel` = 2 (period mode), a rising edge of `ext_in` flips an armed flag. The edge is seen when `ext_in` is 1 this cycle and was 0 at the previous edge. A tick counts only when the flag was already set before that edge. The flag is cleared whenever another mode is selected. With `mode_sel` = 3, nothing is counted.
- R8: `clear` = 1 sets the count to 000 at the next edge and also drops the period armed flag. This holds even when a tick arrives in the same cycle.
- R9: With `irq_sel` = 0, `irq` pulses for one cycle, together with the increment that makes the tens and units digits both 0.
- R10: With `irq_sel` = 1, `irq` pulses for one cycle, together with the increment that makes all three digits 0.
- R11: `irq` is 0 in every cycle that does not follow a counted increment. A clear never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1k | input | 1 | 1 kHz tick strobe, one cycle wide |
| ext_in | input | 1 | Synchronised external gate pin |
| mode_sel | input | 2 | 0 software, 1 pulse width, 2 period, 3 hold |
| sw_run | input | 1 | Software run bit |
| clear | input | 1 | Software clear, zeros the count |
| irq_sel | input | 1 | 0 tenth-second boundary, 1 one-second boundary |
| count_bcd | output | 12 | Three BCD digits, hundreds in bits 11:8 |
| irq | output | 1 | Boundary interrupt strobe |

## Verification
The hardest conditions to reach are the 999 to 000 wrap and the one-second interrupt, because each takes a thousand counted ticks. The bench asserts the tick on every cycle in software mode and runs through the whole range twice, swapping the boundary select between passes. Period mode also needs edge and tick coincidences: an arming edge and a tick in the same cycle, and a disarming edge and a tick in the same cycle. A pseudo-random pin pattern with ticks on every cycle produces both, and a bench model predicts the result.

// File: rtl/msc_pkg.sv
// Package: shared definitions for the decimal stopwatch counter.
// Assumes: the mode encoding is fixed by the control interface.
package msc_pkg;
    typedef enum logic [1:0] {
        MSC_MODE_SOFT   = 2'd0,
        MSC_MODE_WIDTH  = 2'd1,
        MSC_MODE_PERIOD = 2'd2,
        MSC_MODE_HOLD   = 2'd3
    } msc_mode_e;

    localparam int unsigned MSC_DIGIT_W = 4;
endpackage

// File: rtl/msc_run_gate.sv
// Module: msc_run_gate
// Decides whether a tick may advance the count, based on the selected mode.
// Assumes: ext_in is already synchronised to clk; clear disarms period mode.
module msc_run_gate
    import msc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  msc_mode_e mode,
    input  logic      sw_run,
    input  logic      ext_in,
    input  logic      clear,
    output logic      run_en
);
    logic ext_q;
    logic armed;
    logic ext_rise;

    assign ext_rise = ext_in & ~ext_q;

    // Keep the previous pin level so edges can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_in;
    end

    // Period mode: each rising edge flips the armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                        armed <= 1'b0;
        else if (clear)                    armed <= 1'b0;
        else if (mode != MSC_MODE_PERIOD)  armed <= 1'b0;
        else if (ext_rise)                 armed <= ~armed;
    end

    // Pick the enable source for the current mode.
    always_comb begin
        unique case (mode)
            MSC_MODE_SOFT:   run_en = sw_run;
            MSC_MODE_WIDTH:  run_en = ext_in;
            MSC_MODE_PERIOD: run_en = armed;
            default:         run_en = 1'b0;
        endcase
    end

    // R7: in period mode, a rising edge without clear flips the armed state.
    assert_period_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MSC_MODE_PERIOD && ext_in && !ext_q && !clear) |=> (armed != $past(armed)));

    // R8: clear always leaves the gate disarmed.
    assert_clear_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !armed);
endmodule

// File: rtl/msc_bcd_digit.sv
// Module: msc_bcd_digit
// One decimal digit: counts 0..9 and emits a carry when stepping past 9.
// Assumes: clear has priority over inc.
module msc_bcd_digit
    import msc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   inc,
    output logic [MSC_DIGIT_W-1:0] value,
    output logic                   carry
);
    localparam logic [MSC_DIGIT_W-1:0] DIGIT_MAX = MSC_DIGIT_W'(9);

    assign carry = inc & (value == DIGIT_MAX);

    // Advance the digit with decimal wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)     value <= '0;
        else if (clear) value <= '0;
        else if (inc)   value <= (value == DIGIT_MAX) ? '0 : value + 1'b1;
    end

    // R2: a digit never leaves the decimal range.
    assert_digit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        value <= DIGIT_MAX);

    // R2: a carry-out leaves the digit at zero.
    assert_carry_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !clear) |=> (value == '0));
endmodule

// File: rtl/msc_bcd_chain.sv
// Module: msc_bcd_chain
// Cascade of decimal digits; carry k means digits 0..k all rolled to zero.
// Assumes: inc is already gated by clear at the top.
module msc_bcd_chain
    import msc_pkg::*;
#(
    parameter int unsigned DIGITS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          inc,
    output logic [DIGITS*MSC_DIGIT_W-1:0] value,
    output logic [DIGITS-1:0]             carry
);
    logic [DIGITS:0] chain_in;

    assign chain_in[0] = inc;

    genvar g;
    generate
        for (g = 0; g < DIGITS; g++) begin : g_digit
            msc_bcd_digit u_digit (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (clear),
                .inc   (chain_in[g]),
                .value (value[g*MSC_DIGIT_W +: MSC_DIGIT_W]),
                .carry (carry[g])
            );
            assign chain_in[g+1] = carry[g];
        end
    endgenerate
endmodule

// File: rtl/msec_bcd_timer.sv
// Module: msec_bcd_timer
// Three-digit BCD millisecond counter with a mode-selected run gate and a
// decimal-boundary interrupt strobe.
// Assumes: tick_1k is a one-cycle strobe; ext_in is synchronised.
module msec_bcd_timer
    import msc_pkg::*;
#(
    parameter int unsigned DIGITS     = 3,
    parameter int unsigned TENTH_SPAN = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_1k,
    input  logic                          ext_in,
    input  logic [1:0]                    mode_sel,
    input  logic                          sw_run,
    input  logic                          clear,
    input  logic                          irq_sel,
    output logic [DIGITS*MSC_DIGIT_W-1:0] count_bcd,
    output logic                          irq
);
    localparam int unsigned TENTH_IDX = TENTH_SPAN - 1;
    localparam int unsigned FULL_IDX  = DIGITS - 1;
    localparam int unsigned LOW_W     = TENTH_SPAN * MSC_DIGIT_W;

    logic              run_en;
    logic              step;
    logic [DIGITS-1:0] carry;

    msc_run_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (msc_mode_e'(mode_sel)),
        .sw_run (sw_run),
        .ext_in (ext_in),
        .clear  (clear),
        .run_en (run_en)
    );

    assign step = tick_1k & run_en & ~clear;

    msc_bcd_chain #(.DIGITS(DIGITS)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .inc   (step),
        .value (count_bcd),
        .carry (carry)
    );

    // Register the boundary strobe alongside the count update.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_sel ? carry[FULL_IDX] : carry[TENTH_IDX];
    end

    // R4: without a tick or clear the count holds.
    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1k && !clear) |=> $stable(count_bcd));

    // R8: clear zeros the count at the next edge.
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_bcd == '0));

    // R9: any strobe coincides with zero low digits.
    assert_irq_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count_bcd[LOW_W-1:0] == '0));

    // R11: a clear cycle never produces a strobe.
    assert_no_irq_on_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !irq);
endmodule

// File: tb/msec_bcd_timer_test.sv
module msec_bcd_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1k = 1'b0;
    logic        ext_in = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        sw_run = 1'b0;
    logic        clear = 1'b0;
    logic        irq_sel = 1'b0;
    logic [11:0] count_bcd;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state
    int  m_cnt = 0;
    bit  m_arm = 0;
    bit  m_ext_prev = 0;
    bit  m_irq = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    msec_bcd_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .ext_in(ext_in),
        .mode_sel(mode_sel), .sw_run(sw_run), .clear(clear), .irq_sel(irq_sel),
        .count_bcd(count_bcd), .irq(irq)
    );

    function automatic logic [11:0] to_bcd(int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic bit prand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[16];
    endfunction

    task automatic check(string req);
        tests++;
        if (count_bcd !== to_bcd(m_cnt) || irq !== m_irq) begin
            fails++;
            $display("FAIL %s: count=%h irq=%b expected count=%h irq=%b",
                     req, count_bcd, irq, to_bcd(m_cnt), m_irq);
        end
    endtask

    // Apply one cycle of inputs (driven at negedge), update model, check at next negedge.
    task automatic step(bit t, bit e, logic [1:0] m, bit s, bit c, bit sel, string req);
        bit en;
        bit rise;
        tick_1k = t; ext_in = e; mode_sel = m; sw_run = s; clear = c; irq_sel = sel;
        case (m)
            2'd0: en = s;
            2'd1: en = e;
            2'd2: en = m_arm;
            default: en = 0;
        endcase
        rise = e && !m_ext_prev;
        if (c) begin
            m_cnt = 0; m_arm = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (t && en) begin
                m_cnt = (m_cnt + 1) % 1000;
                m_irq = sel ? (m_cnt == 0) : (m_cnt % 100 == 0);
            end
            if (m != 2'd2) m_arm = 0;
            else if (rise) m_arm = !m_arm;
        end
        m_ext_prev = e;
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2 R3 R9: full sweep with tenth-second strobe, software mode
        for (int i = 0; i < 1005; i++) step(1, 0, 2'd0, 1, 0, 0, "R2_R3_R9");
        // R10: full sweep with one-second strobe
        for (int i = 0; i < 1000; i++) step(1, 0, 2'd0, 1, 0, 1, "R3_R10");

        // R4 R5: ticks sparse, run bit toggling
        for (int i = 0; i < 400; i++) step(prand(), 0, 2'd0, prand(), 0, 0, "R4_R5");

        // R8 R11: clear with simultaneous tick
        step(1, 0, 2'd0, 1, 1, 0, "R8_R11");
        for (int i = 0; i < 99; i++) step(1, 0, 2'd0, 1, 0, 0, "R9");
        step(1, 0, 2'd0, 1, 1, 0, "R8_R11");

        // R6: pulse-width mode, random pin level
        for (int i = 0; i < 600; i++) step(1, prand(), 2'd1, 0, 0, prand(), "R6");

        // R7: period mode, pin changes slowly, ticks every cycle
        step(0, 0, 2'd2, 0, 1, 0, "R8");
        for (int i = 0; i < 600; i++) begin
            bit e = (((i / 7) % 2) == 1);
            step(1, e, 2'd2, 0, 0, 0, "R7");
        end
        // R7: period mode, random pin and ticks
        for (int i = 0; i < 800; i++) step(prand(), prand(), 2'd2, 1, 0, 0, "R7");
        // R7 R8: clear disarms while armed
        step(1, 0, 2'd2, 0, 0, 0, "R7");
        step(1, 1, 2'd2, 0, 0, 0, "R7");
        step(1, 1, 2'd2, 0, 1, 0, "R8");
        for (int i = 0; i < 5; i++) step(1, 1, 2'd2, 0, 0, 0, "R8");
        // R7: leaving period mode disarms
        step(1, 0, 2'd2, 0, 0, 0, "R7");
        step(1, 1, 2'd2, 0, 0, 0, "R7");
        step(1, 1, 2'd3, 1, 0, 0, "R7");
        for (int i = 0; i < 5; i++) step(1, 1, 2'd2, 0, 0, 0, "R7");
        // R7: hold mode ignores everything
        for (int i = 0; i < 50; i++) step(1, prand(), 2'd3, 1, 0, 0, "R7_hold");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule